// File: doc/BRIEF.md
# Lane-Keyed Iterative Feistel Block Cipher

This block encrypts one 32-bit block under a 64-bit key. It runs one Feistel round per clock over 16-bit halves for 32 rounds. The round keys are not stored as a full schedule. A sliding four-word window produces each new key word during the round that consumes the oldest word of the window.

A 2-bit lane index changes the order in which each group of four expanded key words is used. One key therefore gives four distinct permutations, one per lane. Key, block and lane are captured at the input handshake, so the caller may change them freely afterwards.

Both data edges use valid/ready. The input is accepted only while the engine is idle. An offer made while a block is in flight, or while a result is waiting, is ignored and is not queued. The result stays on the output, unchanged, until the consumer takes it with `out_ready`. Only then does the input side open again.

Top module: `lfc_cipher`

## Requirements
- R1: The key is cut into four 16-bit words; word 0 is key bits 63:48, word 1 bits 47:32, word 2 bits 31:16, word 3 bits 15:0.
- R2: The left half starts as block bits 15:0 and the right half as block bits 31:16. The result carries the final right half in bits 31:16 and the final left half in bits 15:0.
- R3: Key words 4..31 are produced one at a time as follows. With t = ror3(k[i+3]) xor k[i+1], k[i+4] = 0xFFFC xor k[i] xor t xor ror1(t), and bit 0 is additionally flipped by bit (63 - i) of 0xFA2561CDF44AC398.
- R4: Each round takes f = (rol1(L) and rol8(L)) xor rol2(L). The new L is R xor f xor round key, and the new R is the old L.
- R5: Round 4g+j uses key word 4g + ((j + lane) mod 4), where lane is the value captured at the handshake.
- R6: Exactly 32 rounds are applied. `out_valid` rises 32 clock edges after the edge that accepts the input.
- R7: `in_ready` is high only when the engine is idle. An input offered while a block is being processed or a result is pending has no effect on that result and does not start a new operation.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_block` holds its value. On the edge where both are high, the result is released, and on the following cycle `in_ready` is high and `busy` is low.
- R9: After reset, `in_ready` is 1, `busy` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A block, key and lane are offered |
| in_ready | output | 1 | Engine idle; the offer is taken on this edge |
| in_block | input | 32 | Block to encrypt |
| in_key | input | 64 | Cipher key |
| in_lane | input | 2 | Lane index that rotates key use within each group of four |
| busy | output | 1 | Rounds are being applied |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_block | output | 32 | Encrypted block |

## Verification
The result is due exactly 32 edges after the accepting edge. The bench counts falling edges from that handshake until it sees `out_valid`, and expects a count of 32. The result is sampled in that same half-cycle and compared with an arithmetic model built from R1 to R5. Between the handshake and the result, the bench keeps offering altered inputs, so any leak of a second offer shows up as a mismatch. During a consumer stall of zero to three cycles, the held value is checked. One cycle after the release edge, the bench confirms that the engine is idle again.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  localparam int HALF_W = 16;
  localparam int GROUP  = 4;

  typedef logic [HALF_W-1:0] half_t;

  localparam logic [63:0] Z_SEQ     = 64'hFA2561CDF44AC398;
  localparam half_t       KEY_CONST = 16'hFFFC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } lfc_state_e;

  function automatic half_t rotl(input half_t x, input int unsigned n);
    half_t wide_hi;
    half_t wide_lo;
    wide_hi = x << n;
    wide_lo = x >> (HALF_W - n);
    return wide_hi | wide_lo;
  endfunction

  function automatic half_t rotr(input half_t x, input int unsigned n);
    return rotl(x, HALF_W - n);
  endfunction

endpackage

// File: rtl/lfc_keywin.sv
module lfc_keywin
  import lfc_pkg::*;
#(
  parameter int ROUND_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [4*HALF_W-1:0]  key,
  input  logic [1:0]           lane,
  input  logic                 step,
  input  logic [ROUND_W-1:0]   rnd,
  output half_t                rkey
);

  half_t win [GROUP];
  half_t grp [GROUP];
  half_t t_mix;
  half_t new_word;
  logic  [5:0] z_idx;
  logic  [1:0] lane_q;
  logic  [1:0] sel;
  logic        group_end;

  assign z_idx     = 6'd63 - 6'(rnd);
  assign t_mix     = rotr(win[3], 3) ^ win[1];
  assign new_word  = KEY_CONST ^ win[0] ^ t_mix ^ rotr(t_mix, 1) ^ half_t'(Z_SEQ[z_idx]);
  assign sel       = rnd[1:0] + lane_q;
  assign rkey      = grp[sel];
  assign group_end = (rnd[1:0] == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else if (load) lane_q <= lane;
  end

  for (genvar w = 0; w < GROUP; w++) begin : g_word
    half_t slide_in;
    if (w == GROUP - 1) begin : g_tail
      assign slide_in = new_word;
    end else begin : g_body
      assign slide_in = win[w+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[w] <= '0;
        grp[w] <= '0;
      end else if (load) begin
        win[w] <= key[4*HALF_W-1-HALF_W*w -: HALF_W];
        grp[w] <= key[4*HALF_W-1-HALF_W*w -: HALF_W];
      end else if (step) begin
        win[w] <= slide_in;
        if (group_end) grp[w] <= slide_in;
      end
    end
  end

  a_r3_window_slides: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (win[0] == $past(win[1])) && (win[2] == $past(win[3])));

  a_r5_group_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !group_end) |=> $stable(grp[0]) && $stable(grp[3]));

endmodule

// File: rtl/lfc_round.sv
module lfc_round
  import lfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2*HALF_W-1:0] blk,
  input  logic                step,
  input  half_t               rkey,
  output half_t               l_q,
  output half_t               r_q
);

  half_t f_val;

  assign f_val = (rotl(l_q, 1) & rotl(l_q, 8)) ^ rotl(l_q, 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load) begin
      l_q <= blk[HALF_W-1:0];
      r_q <= blk[2*HALF_W-1:HALF_W];
    end else if (step) begin
      l_q <= r_q ^ f_val ^ rkey;
      r_q <= l_q;
    end
  end

  a_r4_right_takes_left: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (r_q == $past(l_q)));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(l_q) && $stable(r_q));

endmodule

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
#(
  parameter int ROUNDS  = 32,
  parameter int ROUND_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               out_ready,
  output logic               load,
  output logic               step,
  output logic [ROUND_W-1:0] rnd,
  output logic               in_ready,
  output logic               busy,
  output logic               out_valid
);

  localparam logic [ROUND_W-1:0] LAST = ROUND_W'(ROUNDS - 1);

  lfc_state_e state;

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state == ST_RUN);
  assign out_valid = (state == ST_HOLD);
  assign load      = in_ready && in_valid;
  assign step      = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rnd   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          rnd   <= '0;
        end
        ST_RUN: begin
          rnd <= rnd + 1'b1;
          if (rnd == LAST) state <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_last_round_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rnd == LAST) |=> out_valid);

  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rnd != LAST) |=> busy);

  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !in_ready && rnd == '0));

  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

endmodule

// File: rtl/lfc_cipher.sv
module lfc_cipher
  import lfc_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*HALF_W-1:0] in_block,
  input  logic [4*HALF_W-1:0] in_key,
  input  logic [1:0]          in_lane,
  output logic                busy,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*HALF_W-1:0] out_block
);

  localparam int ROUND_W = $clog2(ROUNDS);

  logic               load;
  logic               step;
  logic [ROUND_W-1:0] rnd;
  half_t              rkey;
  half_t              l_q;
  half_t              r_q;

  lfc_ctrl #(.ROUNDS(ROUNDS), .ROUND_W(ROUND_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .load      (load),
    .step      (step),
    .rnd       (rnd),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid)
  );

  lfc_keywin #(.ROUND_W(ROUND_W)) u_keys (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .key   (in_key),
    .lane  (in_lane),
    .step  (step),
    .rnd   (rnd),
    .rkey  (rkey)
  );

  lfc_round u_round (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .blk   (in_block),
    .step  (step),
    .rkey  (rkey),
    .l_q   (l_q),
    .r_q   (r_q)
  );

  assign out_block = {r_q, l_q};

  a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_block));

  a_r7_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_ready, busy, out_valid}));

endmodule

// File: tb/lfc_cipher_test.sv
module lfc_cipher_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_block;
  logic [63:0] in_key;
  logic [1:0]  in_lane;
  logic        busy;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_block;

  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;
  logic [31:0] lcg = 32'h1234_abcd;

  always #2 clk = ~clk;

  lfc_cipher uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .in_key    (in_key),
    .in_lane   (in_lane),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // Arithmetic model: full schedule, straight from R1..R5
  function automatic logic [31:0] model(input logic [31:0] pt, input logic [63:0] key, input logic [1:0] lane);
    logic [15:0] k [32];
    logic [15:0] t, l, r, f, nl, rk;
    logic [63:0] zc;
    zc = 64'hFA2561CDF44AC398;
    for (int i = 0; i < 4; i++) k[i] = key[63-16*i -: 16];
    for (int i = 0; i < 28; i++) begin
      t = {k[i+3][2:0], k[i+3][15:3]} ^ k[i+1];
      k[i+4] = 16'hFFFC ^ k[i] ^ t ^ {t[0], t[15:1]} ^ {15'd0, zc[63-i]};
    end
    l = pt[15:0];
    r = pt[31:16];
    for (int i = 0; i < 32; i++) begin
      rk = k[(i / 4) * 4 + ((i + int'(lane)) % 4)];
      f  = ({l[14:0], l[15]} & {l[7:0], l[15:8]}) ^ {l[13:0], l[15:14]};
      nl = r ^ f ^ rk;
      r  = l;
      l  = nl;
    end
    return {r, l};
  endfunction

  task automatic run_op(input logic [31:0] pt, input logic [63:0] key, input logic [1:0] lane, input int stall);
    logic [31:0] exp;
    logic [31:0] got;
    int n;
    exp = model(pt, key, lane);
    @(negedge clk);
    in_block = pt;
    in_key   = key;
    in_lane  = lane;
    in_valid = 1'b1;
    chk(in_ready == 1'b1, "R7 idle ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    // keep offering altered inputs while busy (R7)
    in_block = ~pt;
    in_key   = ~key;
    in_lane  = lane + 2'd1;
    chk(busy && !in_ready, "R7 busy blocks input", {62'd0, busy, in_ready}, 64'd2);
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n == 32, "R6 latency", 64'(n), 64'd32);
    got = out_block;
    chk(got == exp, "R1 R2 R3 R4 R5 result", 64'(got), 64'(exp));
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk(out_valid && out_block == got, "R8 stall hold", {31'd0, out_valid, out_block}, {31'd0, 1'b1, got});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready && !busy, "R8 release", {61'd0, out_valid, in_ready, busy}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    in_block  = '0;
    in_key    = '0;
    in_lane   = '0;
    repeat (3) @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R9 reset state", {61'd0, in_ready, busy, out_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R9 after release", {61'd0, in_ready, busy, out_valid}, 64'd4);

    for (int ln = 0; ln < 4; ln++) begin
      run_op(32'h0000_0000, 64'h0, 2'(ln), 0);                   // R3 constants only
      run_op(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'(ln), 1);
      run_op(32'h1234_5678, 64'h0001_0000_0000_0000, 2'(ln), 2); // R1 word 0 alone
      run_op(32'h1234_5678, 64'h0000_0000_0000_0001, 2'(ln), 3); // R1 word 3 alone
      run_op(32'h0000_0001, 64'h0F0E_0D0C_0B0A_0908, 2'(ln), 0); // R2 low half seed
      run_op(32'h0001_0000, 64'h0F0E_0D0C_0B0A_0908, 2'(ln), 1); // R2 high half seed
      for (int v = 0; v < 6; v++) begin
        logic [31:0] p;
        logic [63:0] k;
        p = next_rand();
        k = {next_rand(), next_rand()};
        run_op(p, k, 2'(ln), v % 4);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule